// File: doc/BRIEF.md
# Timer interrupt status flag unit

This block keeps the six interrupt status flags of a general purpose timer: an update flag, one flag per capture/compare channel (four by default) and a commutation flag. It watches event strobes from the timer's counter, channel and control logic, qualifies them against the update configuration and a repetition down-counter, and records them as sticky bits. Software clears the bits through a small register bus. The block drives a masked interrupt request and a one-cycle update-event pulse.

The repetition down-counter thins counter overflows and underflows, so only every (N+1)-th of them becomes an update. The update-disable and update-source configuration bits decide whether software or trigger reinitialisations raise the update flag. The counter, compare and capture datapaths live outside the block. A bus read of a channel's capture/compare register address is visible here only so that an input-mode channel flag can be cleared.

Top module: `tim_irq_flags`

## Requirements
- R1: After reset, every flag is 0, `irq_o` is 0, `upd_evt_o` is 0 and the repetition counter is 0. Flag layout: bit 0 is update, bits 1..NUM_CH are channels 1..NUM_CH, and bit NUM_CH+1 is commutation.
- R2: A cycle with `cnt_ovf_i` or `cnt_unf_i` high, with the repetition counter at zero and `upd_dis_i` low, sets flag bit 0 and pulses `upd_evt_o` after that clock edge. With `upd_dis_i` high, neither happens.
- R3: Each overflow or underflow decrements a non-zero repetition counter. At zero, the next overflow or underflow reloads the counter from the repetition register (bus address 2) and produces the update. With a reload value N, counted from a zero counter, updates occur on overflows 1, N+2, 2N+3 and so on.
- R4: `sw_ug_i` pulses `upd_evt_o` whenever `upd_dis_i` is 0. It sets flag bit 0 only when both `upd_src_i` and `upd_dis_i` are 0.
- R5: `trg_reinit_i` follows the same rule as R4.
- R6: A channel with `ch_is_input_i[k]` low sets flag bit k+1 on `cmp_match_i[k]` and ignores `cap_edge_i[k]`.
- R7: A channel with `ch_is_input_i[k]` high sets flag bit k+1 on `cap_edge_i[k]` and ignores `cmp_match_i[k]`.
- R8: A bus read of address 4+k clears flag bit k+1 when channel k is in input mode. The same read leaves the flag of an output-mode channel unchanged.
- R9: `com_evt_i` sets the top flag bit. Only a bus write clears it; bus reads do not.
- R10: A bus write to address 0 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged.
- R11: When a hardware set and a software clear hit the same flag in the same cycle, the flag ends up set.
- R12: `irq_o` equals the OR of flags ANDed bitwise with the interrupt-enable register (bus address 1, same bit layout), and follows a flag or enable change with no extra cycle.
- R13: A bus read updates `bus_rdata_o` one cycle later: address 0 returns the flags, address 1 the enable register, address 2 the repetition register, and any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cnt_ovf_i | input | 1 | Counter overflow strobe |
| cnt_unf_i | input | 1 | Counter underflow strobe |
| sw_ug_i | input | 1 | Software update-generate strobe |
| trg_reinit_i | input | 1 | Trigger-driven reinitialise strobe |
| upd_dis_i | input | 1 | Update disable |
| upd_src_i | input | 1 | Update source select (1: only overflow/underflow raises the flag) |
| ch_is_input_i | input | NUM_CH | Per-channel mode, 1 = capture input |
| cmp_match_i | input | NUM_CH | Per-channel compare match strobe |
| cap_edge_i | input | NUM_CH | Per-channel capture strobe |
| com_evt_i | input | 1 | Commutation event strobe |
| bus_we_i | input | 1 | Bus write enable |
| bus_re_i | input | 1 | Bus read enable |
| bus_addr_i | input | ADDR_W | Bus address |
| bus_wdata_i | input | DATA_W | Bus write data |
| bus_rdata_o | output | DATA_W | Registered bus read data |
| flags_o | output | NUM_CH+2 | Flag register |
| irq_o | output | 1 | Masked interrupt request |
| upd_evt_o | output | 1 | Update event pulse |

## Verification
The main same-cycle collision is a hardware set landing in the cycle where software writes a clear to the flag register. The bench raises a compare match on channel 1 during a write of zero to address 0 and expects bit 1 to survive while every other flag is cleared. A second collision pairs a bus read of an input channel's capture address with a fresh capture on that channel; the flag must stay set because the set has priority. Enable writes and flag sets that land in the same cycle are judged on `irq_o` at the next sample.

// File: rtl/tim_flag_pkg.sv
package tim_flag_pkg;
  localparam int ADDR_FLAGS    = 0;
  localparam int ADDR_IEN      = 1;
  localparam int ADDR_RELOAD   = 2;
  localparam int ADDR_CCR_BASE = 4;

  typedef struct packed {
    logic flag_set;
    logic evt;
  } upd_req_t;
endpackage

// File: rtl/tim_rep_counter.sv
module tim_rep_counter #(
  parameter int REP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             tick_i,
  input  logic [REP_W-1:0] reload_i,
  output logic             zero_tick_o
);
  logic [REP_W-1:0] cnt_q;

  assign zero_tick_o = tick_i && (cnt_q == '0);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q == '0) cnt_q <= reload_i;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/tim_upd_qual.sv
module tim_upd_qual
  import tim_flag_pkg::*;
(
  input  logic     ovf_upd_i,
  input  logic     sw_ug_i,
  input  logic     trg_i,
  input  logic     upd_dis_i,
  input  logic     upd_src_i,
  output upd_req_t req_o
);
  logic soft_src;

  always_comb begin
    soft_src       = sw_ug_i || trg_i;
    req_o.evt      = !upd_dis_i && (ovf_upd_i || soft_src);
    req_o.flag_set = !upd_dis_i && (ovf_upd_i || (!upd_src_i && soft_src));
  end
endmodule

// File: rtl/tim_flag_bit.sv
module tim_flag_bit (
  input  logic clk_i,
  input  logic rst_i,
  input  logic set_i,
  input  logic clr_i,
  output logic nxt_o,
  output logic q_o
);
  always_comb begin
    if (set_i)      nxt_o = 1'b1;
    else if (clr_i) nxt_o = 1'b0;
    else            nxt_o = q_o;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) q_o <= 1'b0;
    else       q_o <= nxt_o;
  end
endmodule

// File: rtl/tim_irq_flags.sv
module tim_irq_flags
  import tim_flag_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int REP_W  = 8,
  parameter int FLAG_W = NUM_CH + 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              cnt_ovf_i,
  input  logic              cnt_unf_i,
  input  logic              sw_ug_i,
  input  logic              trg_reinit_i,
  input  logic              upd_dis_i,
  input  logic              upd_src_i,
  input  logic [NUM_CH-1:0] ch_is_input_i,
  input  logic [NUM_CH-1:0] cmp_match_i,
  input  logic [NUM_CH-1:0] cap_edge_i,
  input  logic              com_evt_i,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              irq_o,
  output logic              upd_evt_o
);
  localparam logic [ADDR_W-1:0] A_FLAGS  = ADDR_W'(ADDR_FLAGS);
  localparam logic [ADDR_W-1:0] A_IEN    = ADDR_W'(ADDR_IEN);
  localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(ADDR_RELOAD);
  localparam int COM_BIT = FLAG_W - 1;

  logic [FLAG_W-1:0] ien_q, ien_nxt;
  logic [REP_W-1:0]  reload_q;
  logic [FLAG_W-1:0] set_vec, clr_vec, flag_nxt;
  logic [FLAG_W-1:0] wr_clr;
  logic [NUM_CH-1:0] rd_ccr;
  logic              ovf_upd;
  logic              irq_q, upd_evt_q;
  logic [DATA_W-1:0] rdata_q, rdata_nxt;
  upd_req_t          upd_req;

  tim_rep_counter #(.REP_W(REP_W)) u_rep (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .tick_i     (cnt_ovf_i || cnt_unf_i),
    .reload_i   (reload_q),
    .zero_tick_o(ovf_upd)
  );

  tim_upd_qual u_qual (
    .ovf_upd_i(ovf_upd),
    .sw_ug_i  (sw_ug_i),
    .trg_i    (trg_reinit_i),
    .upd_dis_i(upd_dis_i),
    .upd_src_i(upd_src_i),
    .req_o    (upd_req)
  );

  // software clear: a 0 in the written data clears the matching flag
  assign wr_clr = (bus_we_i && bus_addr_i == A_FLAGS) ? ~bus_wdata_i[FLAG_W-1:0] : '0;

  assign set_vec[0]       = upd_req.flag_set;
  assign clr_vec[0]       = wr_clr[0];
  assign set_vec[COM_BIT] = com_evt_i;
  assign clr_vec[COM_BIT] = wr_clr[COM_BIT];

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    assign rd_ccr[k]    = bus_re_i && ch_is_input_i[k]
                          && (bus_addr_i == ADDR_W'(ADDR_CCR_BASE + k));
    assign set_vec[k+1] = ch_is_input_i[k] ? cap_edge_i[k] : cmp_match_i[k];
    assign clr_vec[k+1] = wr_clr[k+1] || rd_ccr[k];
  end

  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    tim_flag_bit u_bit (
      .clk_i(clk_i),
      .rst_i(rst_i),
      .set_i(set_vec[i]),
      .clr_i(clr_vec[i]),
      .nxt_o(flag_nxt[i]),
      .q_o  (flags_o[i])
    );
  end

  assign ien_nxt = (bus_we_i && bus_addr_i == A_IEN) ? bus_wdata_i[FLAG_W-1:0] : ien_q;

  always_comb begin
    rdata_nxt = '0;
    if (bus_addr_i == A_FLAGS)       rdata_nxt[FLAG_W-1:0] = flags_o;
    else if (bus_addr_i == A_IEN)    rdata_nxt[FLAG_W-1:0] = ien_q;
    else if (bus_addr_i == A_RELOAD) rdata_nxt[REP_W-1:0]  = reload_q;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ien_q     <= '0;
      reload_q  <= '0;
      irq_q     <= 1'b0;
      upd_evt_q <= 1'b0;
      rdata_q   <= '0;
    end else begin
      ien_q     <= ien_nxt;
      irq_q     <= |(flag_nxt & ien_nxt);
      upd_evt_q <= upd_req.evt;
      if (bus_we_i && bus_addr_i == A_RELOAD) reload_q <= bus_wdata_i[REP_W-1:0];
      if (bus_re_i) rdata_q <= rdata_nxt;
    end
  end

  assign irq_o       = irq_q;
  assign upd_evt_o   = upd_evt_q;
  assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/tim_irq_flags_chk.sv
module tim_irq_flags_chk #(
  parameter int NUM_CH = 4,
  parameter int FLAG_W = NUM_CH + 2
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              cnt_ovf_i,
  input logic              cnt_unf_i,
  input logic              sw_ug_i,
  input logic              trg_reinit_i,
  input logic              upd_dis_i,
  input logic              com_evt_i,
  input logic [NUM_CH-1:0] ch_is_input_i,
  input logic [NUM_CH-1:0] cmp_match_i,
  input logic [FLAG_W-1:0] flags_o,
  input logic [FLAG_W-1:0] ien_q,
  input logic              irq_o,
  input logic              upd_evt_o
);
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_o == |(flags_o & ien_q)); // R12

  AST_UPD_DIS_SILENCES: assert property (@(posedge clk_i) disable iff (rst_i)
    upd_dis_i |=> !upd_evt_o); // R2

  AST_UIF_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (rst_i)
    !(cnt_ovf_i || cnt_unf_i || sw_ug_i || trg_reinit_i) && !flags_o[0] |=> !flags_o[0]); // R4

  AST_COM_SETS: assert property (@(posedge clk_i) disable iff (rst_i)
    com_evt_i |=> flags_o[FLAG_W-1]); // R9

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
    AST_OUT_MATCH_SETS: assert property (@(posedge clk_i) disable iff (rst_i)
      (cmp_match_i[k] && !ch_is_input_i[k]) |=> flags_o[k+1]); // R6
  end
endmodule

bind tim_irq_flags tim_irq_flags_chk #(.NUM_CH(NUM_CH), .FLAG_W(FLAG_W)) u_chk (
  .clk_i        (clk_i),
  .rst_i        (rst_i),
  .cnt_ovf_i    (cnt_ovf_i),
  .cnt_unf_i    (cnt_unf_i),
  .sw_ug_i      (sw_ug_i),
  .trg_reinit_i (trg_reinit_i),
  .upd_dis_i    (upd_dis_i),
  .com_evt_i    (com_evt_i),
  .ch_is_input_i(ch_is_input_i),
  .cmp_match_i  (cmp_match_i),
  .flags_o      (flags_o),
  .ien_q        (ien_q),
  .irq_o        (irq_o),
  .upd_evt_o    (upd_evt_o)
);

// File: tb/tim_irq_flags_tb.sv
module tim_irq_flags_tb;
  localparam int NC = 4;
  localparam int FW = NC + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ovf = 0, unf = 0, ug = 0, trg = 0, udis = 0, usrc = 0, com = 0;
  logic [NC-1:0] chin = '0, cmpm = '0, cape = '0;
  logic we = 0, re = 0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [FW-1:0] flags;
  logic irq, uevt;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  tim_irq_flags u_dut (
    .clk_i(clk), .rst_i(rst), .cnt_ovf_i(ovf), .cnt_unf_i(unf), .sw_ug_i(ug),
    .trg_reinit_i(trg), .upd_dis_i(udis), .upd_src_i(usrc), .ch_is_input_i(chin),
    .cmp_match_i(cmpm), .cap_edge_i(cape), .com_evt_i(com), .bus_we_i(we),
    .bus_re_i(re), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .flags_o(flags), .irq_o(irq), .upd_evt_o(uevt)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input int a, input int d);
    we = 1; addr = 3'(a); wdata = 8'(d);
    step();
    we = 0;
  endtask

  task automatic bus_rd(input int a, output int d);
    re = 1; addr = 3'(a);
    step();
    re = 0;
    d = int'(rdata);
  endtask

  task automatic clear_all();
    bus_wr(0, 0);
  endtask

  task automatic t_reset();
    check("R1 flags", int'(flags), 0);
    check("R1 irq", int'(irq), 0);
    check("R1 uevt", int'(uevt), 0);
  endtask

  task automatic t_ovf();
    ovf = 1; step(); ovf = 0;
    check("R2 ovf flag", int'(flags), 1);
    check("R2 ovf evt", int'(uevt), 1);
    step();
    check("R2 evt one cycle", int'(uevt), 0);
    bus_wr(0, 8'h3E);
    check("R10 clear bit0", int'(flags), 0);
    unf = 1; step(); unf = 0;
    check("R2 unf flag", int'(flags), 1);
    clear_all();
    udis = 1; ovf = 1; step(); ovf = 0;
    check("R2 udis flag", int'(flags), 0);
    check("R2 udis evt", int'(uevt), 0);
    udis = 0;
  endtask

  task automatic t_rep();
    bus_wr(2, 2);
    for (int n = 1; n <= 9; n++) begin
      int e;
      e = ((n - 1) % 3 == 0) ? 1 : 0;
      ovf = 1; step(); ovf = 0;
      check("R3 rep evt", int'(uevt), e);
      check("R3 rep flag", int'(flags[0]), e);
      clear_all();
    end
    bus_wr(2, 0);
  endtask

  task automatic t_soft(input bit use_trg);
    string tag;
    tag = use_trg ? "R5" : "R4";
    usrc = 0; udis = 0;
    if (use_trg) trg = 1; else ug = 1;
    step(); trg = 0; ug = 0;
    check({tag, " src0 flag"}, int'(flags), 1);
    check({tag, " src0 evt"}, int'(uevt), 1);
    clear_all();
    usrc = 1;
    if (use_trg) trg = 1; else ug = 1;
    step(); trg = 0; ug = 0;
    check({tag, " src1 flag"}, int'(flags), 0);
    check({tag, " src1 evt"}, int'(uevt), 1);
    usrc = 0; udis = 1;
    if (use_trg) trg = 1; else ug = 1;
    step(); trg = 0; ug = 0;
    check({tag, " dis flag"}, int'(flags), 0);
    check({tag, " dis evt"}, int'(uevt), 0);
    udis = 0;
  endtask

  task automatic t_channels();
    chin = 4'b0000;
    cape = 4'b1111; step(); cape = '0;
    check("R6 capture ignored", int'(flags), 0);
    cmpm = 4'b0101; step(); cmpm = '0;
    check("R6 match sets", int'(flags), 6'b001010);
    clear_all();
    chin = 4'b1111;
    cmpm = 4'b1111; step(); cmpm = '0;
    check("R7 match ignored", int'(flags), 0);
    cape = 4'b1010; step(); cape = '0;
    check("R7 capture sets", int'(flags), 6'b010100);
    clear_all();
  endtask

  task automatic t_read_clear();
    int d;
    chin = 4'b0010;
    cape = 4'b0010; cmpm = 4'b0001; step(); cape = '0; cmpm = '0;
    check("R8 setup", int'(flags), 6'b000110);
    bus_rd(5, d);
    check("R8 input read clears", int'(flags), 6'b000010);
    bus_rd(4, d);
    check("R8 output read keeps", int'(flags), 6'b000010);
    bus_rd(4, d);
    check("R13 other addr zero", d, 0);
    cape = 4'b0010; step(); cape = '0;
    re = 1; addr = 3'd5; cape = 4'b0010; step(); re = 0; cape = '0;
    check("R11 read vs capture", int'(flags), 6'b000110);
    clear_all(); chin = '0;
  endtask

  task automatic t_com();
    int d;
    com = 1; step(); com = 0;
    check("R9 com set", int'(flags), 6'b100000);
    bus_rd(0, d);
    bus_rd(7, d);
    check("R9 read keeps", int'(flags), 6'b100000);
    bus_wr(0, 8'h1F);
    check("R9 write clears", int'(flags), 0);
  endtask

  task automatic t_write();
    com = 1; cmpm = 4'b1111; step(); com = 0; cmpm = '0;
    bus_wr(0, 8'hFF);
    check("R10 ones keep", int'(flags), 6'b111110);
    bus_wr(0, 8'hF7);
    check("R10 clear bit3", int'(flags), 6'b110110);
    we = 1; addr = 3'd0; wdata = 8'h00; cmpm = 4'b0001; step(); we = 0; cmpm = '0;
    check("R11 set wins", int'(flags), 6'b000010);
    clear_all();
  endtask

  task automatic t_irq();
    int d;
    cmpm = 4'b0100; step(); cmpm = '0;
    check("R12 masked", int'(irq), 0);
    bus_wr(1, 8'h08);
    check("R12 enable", int'(irq), 1);
    bus_rd(1, d);
    check("R13 read ien", d, 8'h08);
    bus_rd(0, d);
    check("R13 read flags", d, 8'h08);
    bus_wr(0, 0);
    check("R12 clear drops", int'(irq), 0);
    bus_wr(2, 8'hA5);
    bus_rd(2, d);
    check("R13 read reload", d, 8'hA5);
    bus_wr(2, 0);
    bus_wr(1, 8'h01);
    com = 1; step(); com = 0;
    check("R12 other bit masked", int'(irq), 0);
    clear_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst = 0;
    step();
    t_reset();
    t_ovf();
    t_rep();
    t_soft(1'b0);
    t_soft(1'b1);
    t_channels();
    t_read_clear();
    t_com();
    t_write();
    t_irq();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule